// File: doc/BRIEF.md
# Dual-Stream Channel Interleaver

This block joins a pair of 32-bit word streams to a datapath that works on eight 16-bit channel samples at a time, and it does this in both directions. Each 32-bit word carries two neighbouring channels. Two words arrive on each stream over two fast clock cycles, so the datapath receives one eight-channel group every second cycle. On the return side, one eight-channel result group every second cycle is split back into two word pairs and sent on the two output streams. The bandwidth is the same on both sides: two streams times 32 bits at the full rate equals eight channels times 16 bits at half the rate. The interface can therefore run fully loaded in both directions.

The half-rate timing is a clock enable, `half_en`, that the block generates and exports. It is low in the first cycle after reset and then changes value every cycle. The datapath side hands over a group only in a cycle where `half_en` is high. Every edge of the block uses a valid/ready handshake. The unpacker collects a complete group before it offers it, so a stall on either input stream holds back the whole group. The packer drives both output streams together and marks the second word pair of a group whose result carried the last flag.

Top module: `dual_stream_interleaver`

## Requirements
- R1: `half_en` is 0 in the first cycle after reset is released. After that it inverts on every clock cycle.
- R2: While reset is held, the outputs take these values: every `in_ready` bit is 1, `grp_valid` is 0, `res_ready` is 1, both `out_valid` bits are 0 and `out_last` is 0.
- R3: Input word k of stream s belongs to group k/2 and beat b = k mod 2. For channel index h = 2·(2b+s), bits [31:16] of that word go to channel h and bits [15:0] go to channel h+1. In `grp_data`, channel c occupies bits [16c+15:16c].
- R4: `grp_valid` rises only after both beats of both streams have been accepted. If one stream stalls, `grp_valid` stays 0, and a stream that already holds both beats of the current group drops its `in_ready`.
- R5: Once `grp_valid` is high, it stays high with `grp_data` unchanged until a cycle in which `half_en` and `grp_ready` are both high. The group is transferred in that cycle.
- R6: With both input streams valid on every cycle and `grp_ready` held high, both `in_ready` bits stay high and one group is delivered on every `half_en` cycle.
- R7: A result group is taken in a cycle in which `half_en`, `res_valid` and `res_ready` are all high. It leaves as two word pairs: pair 0 carries channels 0–3 and pair 1 carries channels 4–7. Stream s of a pair uses the same channel-to-half mapping as R3, with channel c taken from `res_data` bits [16c+15:16c].
- R8: Both `out_valid` bits are always equal. A word pair advances only in a cycle where both `out_ready` bits are high. Until then the pair is held with `out_data` unchanged.
- R9: `out_last` is 1 only while the second word pair of a result group taken with `res_last`=1 is presented. It is 0 for every other pair.
- R10: With both `out_ready` bits held high, `res_ready` is high in every `half_en` cycle and a word pair leaves on every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| half_en | output | 1 | Half-rate enable for the channel side |
| in_valid | input | 2 | Per-stream input word valid |
| in_ready | output | 2 | Per-stream input word ready |
| in_data | input | 64 | Input words, stream s at bits [32s+31:32s] |
| grp_valid | output | 1 | Eight-channel group available |
| grp_ready | input | 1 | Datapath accepts a group (taken only when half_en is high) |
| grp_data | output | 128 | Unpacked group, channel c at bits [16c+15:16c] |
| res_valid | input | 1 | Result group valid |
| res_ready | output | 1 | Packer can take a result group (taken only when half_en is high) |
| res_data | input | 128 | Result group, channel c at bits [16c+15:16c] |
| res_last | input | 1 | Result group ends a frame |
| out_valid | output | 2 | Per-stream output word valid (always equal) |
| out_ready | input | 2 | Per-stream output word ready |
| out_data | output | 64 | Output words, stream s at bits [32s+31:32s] |
| out_last | output | 1 | End-of-frame on the final word pair |

## Verification
Some properties are checked by assertions on every cycle:
- `half_en` inverts on each cycle.
- A completed collection is offered in the following cycle.
- An offered group, and a presented word pair, both hold steady until they are taken.
- `out_last` never appears without a valid pair.

Other behaviour can only be shown by the bench's scenarios:
- The exact channel-to-half mapping in both directions.
- Holding a group back while one stream stalls.
- Full throughput with no idle cycles.
- Placement of the end-of-frame mark.

The bench shows these with stall patterns on every handshake and with sample values it computes itself.

// File: rtl/ilv_pkg.sv
package ilv_pkg;
  // First (high-half) channel carried by a stream on a given beat.
  function automatic int lane_hi(input int beat, input int strm, input int streams);
    return 2 * (beat * streams + strm);
  endfunction

  // Beats needed to move one full group over all streams.
  function automatic int beats_per_group(input int lanes, input int streams);
    return lanes / (2 * streams);
  endfunction
endpackage

// File: rtl/ilv_phase.sv
module ilv_phase (
  input  logic clk,
  input  logic rst_n,
  output logic half_en
);
  logic phase_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= 1'b0;
    else        phase_q <= ~phase_q;
  end

  assign half_en = phase_q;

  assert_half_toggle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (half_en != $past(half_en)));
endmodule

// File: rtl/ilv_unpack.sv
module ilv_unpack #(
  parameter int SAMPLE_W = 16,
  parameter int STREAMS  = 2,
  parameter int LANES    = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        half_en,
  input  logic [STREAMS-1:0]          in_valid,
  output logic [STREAMS-1:0]          in_ready,
  input  logic [STREAMS*2*SAMPLE_W-1:0] in_data,
  output logic                        grp_valid,
  input  logic                        grp_ready,
  output logic [LANES*SAMPLE_W-1:0]   grp_data
);
  localparam int WORD_W = 2 * SAMPLE_W;
  localparam int BEATS  = ilv_pkg::beats_per_group(LANES, STREAMS);
  localparam int CNT_W  = $clog2(BEATS + 1);

  logic [STREAMS-1:0]        slot_full;
  logic                      move;
  logic                      complete;
  logic                      hold_v;
  logic                      hold_fire;
  logic [LANES*SAMPLE_W-1:0] col_flat;
  logic [LANES*SAMPLE_W-1:0] hold_q;

  assign complete  = &slot_full;
  assign hold_fire = hold_v & half_en & grp_ready;
  assign move      = complete & (~hold_v | hold_fire);

  for (genvar s = 0; s < STREAMS; s++) begin : g_strm
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] wr_beat;
    logic             accept;

    assign slot_full[s] = (cnt_q == CNT_W'(BEATS));
    assign in_ready[s]  = ~slot_full[s] | move;
    assign accept       = in_valid[s] & in_ready[s];
    assign wr_beat      = slot_full[s] ? '0 : cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt_q <= '0;
      else if (move)   cnt_q <= accept ? CNT_W'(1) : '0;
      else if (accept) cnt_q <= cnt_q + CNT_W'(1);
    end

    for (genvar b = 0; b < BEATS; b++) begin : g_beat
      localparam int HI = ilv_pkg::lane_hi(b, s, STREAMS);
      logic [WORD_W-1:0] word_q;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) word_q <= '0;
        else if (accept && wr_beat == CNT_W'(b))
          word_q <= in_data[s*WORD_W +: WORD_W];
      end

      assign col_flat[HI*SAMPLE_W +: SAMPLE_W]     = word_q[WORD_W-1:SAMPLE_W];
      assign col_flat[(HI+1)*SAMPLE_W +: SAMPLE_W] = word_q[SAMPLE_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_v <= 1'b0;
      hold_q <= '0;
    end else if (move) begin
      hold_v <= 1'b1;
      hold_q <= col_flat;
    end else if (hold_fire) begin
      hold_v <= 1'b0;
    end
  end

  assign grp_valid = hold_v;
  assign grp_data  = hold_q;

  assert_group_after_fill_R4: assert property (@(posedge clk) disable iff (!rst_n)
    move |=> grp_valid);

  assert_group_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (grp_valid && !(half_en && grp_ready)) |=> (grp_valid && $stable(grp_data)));
endmodule

// File: rtl/ilv_pack.sv
module ilv_pack #(
  parameter int SAMPLE_W = 16,
  parameter int STREAMS  = 2,
  parameter int LANES    = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          half_en,
  input  logic                          res_valid,
  output logic                          res_ready,
  input  logic [LANES*SAMPLE_W-1:0]     res_data,
  input  logic                          res_last,
  output logic [STREAMS-1:0]            out_valid,
  input  logic [STREAMS-1:0]            out_ready,
  output logic [STREAMS*2*SAMPLE_W-1:0] out_data,
  output logic                          out_last
);
  localparam int WORD_W = 2 * SAMPLE_W;
  localparam int BEATS  = ilv_pkg::beats_per_group(LANES, STREAMS);
  localparam int IDX_W  = (BEATS > 1) ? $clog2(BEATS) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(BEATS - 1);

  logic                      buf_v;
  logic                      buf_last;
  logic [IDX_W-1:0]          beat_q;
  logic [LANES*SAMPLE_W-1:0] buf_q;
  logic                      pair_fire;
  logic                      last_beat;
  logic                      res_take;

  assign pair_fire = buf_v & (&out_ready);
  assign last_beat = (beat_q == LAST_IDX);
  assign res_ready = ~buf_v | (pair_fire & last_beat);
  assign res_take  = half_en & res_valid & res_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_v    <= 1'b0;
      buf_last <= 1'b0;
      beat_q   <= '0;
      buf_q    <= '0;
    end else if (res_take) begin
      buf_v    <= 1'b1;
      buf_last <= res_last;
      beat_q   <= '0;
      buf_q    <= res_data;
    end else if (pair_fire) begin
      if (last_beat) buf_v <= 1'b0;
      else           beat_q <= beat_q + IDX_W'(1);
    end
  end

  for (genvar s = 0; s < STREAMS; s++) begin : g_strm
    logic [WORD_W-1:0] word;

    always_comb begin
      word = '0;
      for (int b = 0; b < BEATS; b++) begin
        if (beat_q == IDX_W'(b))
          word = {buf_q[ilv_pkg::lane_hi(b, s, STREAMS)*SAMPLE_W +: SAMPLE_W],
                  buf_q[(ilv_pkg::lane_hi(b, s, STREAMS)+1)*SAMPLE_W +: SAMPLE_W]};
      end
    end

    assign out_data[s*WORD_W +: WORD_W] = word;
    assign out_valid[s] = buf_v;
  end

  assign out_last = buf_v & buf_last & last_beat;

  assert_pair_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid[0] && !(&out_ready)) |=> (out_valid[0] && $stable(out_data)));

  assert_last_qualified_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> (out_valid[0] && out_valid[STREAMS-1]));
endmodule

// File: rtl/dual_stream_interleaver.sv
module dual_stream_interleaver #(
  parameter int SAMPLE_W = 16,
  parameter int STREAMS  = 2,
  parameter int LANES    = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  output logic                          half_en,
  input  logic [STREAMS-1:0]            in_valid,
  output logic [STREAMS-1:0]            in_ready,
  input  logic [STREAMS*2*SAMPLE_W-1:0] in_data,
  output logic                          grp_valid,
  input  logic                          grp_ready,
  output logic [LANES*SAMPLE_W-1:0]     grp_data,
  input  logic                          res_valid,
  output logic                          res_ready,
  input  logic [LANES*SAMPLE_W-1:0]     res_data,
  input  logic                          res_last,
  output logic [STREAMS-1:0]            out_valid,
  input  logic [STREAMS-1:0]            out_ready,
  output logic [STREAMS*2*SAMPLE_W-1:0] out_data,
  output logic                          out_last
);
  ilv_phase u_phase (
    .clk     (clk),
    .rst_n   (rst_n),
    .half_en (half_en)
  );

  ilv_unpack #(.SAMPLE_W(SAMPLE_W), .STREAMS(STREAMS), .LANES(LANES)) u_unpack (
    .clk       (clk),
    .rst_n     (rst_n),
    .half_en   (half_en),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (in_data),
    .grp_valid (grp_valid),
    .grp_ready (grp_ready),
    .grp_data  (grp_data)
  );

  ilv_pack #(.SAMPLE_W(SAMPLE_W), .STREAMS(STREAMS), .LANES(LANES)) u_pack (
    .clk       (clk),
    .rst_n     (rst_n),
    .half_en   (half_en),
    .res_valid (res_valid),
    .res_ready (res_ready),
    .res_data  (res_data),
    .res_last  (res_last),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data),
    .out_last  (out_last)
  );
endmodule

// File: tb/dual_stream_interleaver_tb_top.sv
module dual_stream_interleaver_tb_top;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         half_en;
  logic [1:0]   in_valid = '0;
  logic [1:0]   in_ready;
  logic [63:0]  in_data = '0;
  logic         grp_valid;
  logic         grp_ready = 1'b0;
  logic [127:0] grp_data;
  logic         res_valid = 1'b0;
  logic         res_ready;
  logic [127:0] res_data = '0;
  logic         res_last = 1'b0;
  logic [1:0]   out_valid;
  logic [1:0]   out_ready = '0;
  logic [63:0]  out_data;
  logic         out_last;

  int n_checks = 0;
  int n_fail   = 0;

  always #2 clk = ~clk;

  dual_stream_interleaver dut_i (
    .clk(clk), .rst_n(rst_n), .half_en(half_en),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .grp_valid(grp_valid), .grp_ready(grp_ready), .grp_data(grp_data),
    .res_valid(res_valid), .res_ready(res_ready), .res_data(res_data), .res_last(res_last),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_last(out_last)
  );

  function automatic logic [15:0] v_in(int g, int c);
    return 16'((g * 389 + c * 4097 + 16'h1357) ^ (g << 5));
  endfunction

  function automatic logic [15:0] v_res(int g, int c);
    return 16'((g * 613 + c * 2731 + 16'h9a4c) ^ (c << 11));
  endfunction

  function automatic logic [31:0] in_word(int k, int s);
    int g = k / 2;
    int h = 2 * (2 * (k % 2) + s);
    return {v_in(g, h), v_in(g, h + 1)};
  endfunction

  function automatic logic [127:0] in_group(int g);
    logic [127:0] r;
    for (int c = 0; c < 8; c++) r[16*c +: 16] = v_in(g, c);
    return r;
  endfunction

  function automatic logic [127:0] res_group(int g);
    logic [127:0] r;
    for (int c = 0; c < 8; c++) r[16*c +: 16] = v_res(g, c);
    return r;
  endfunction

  function automatic logic [63:0] out_pair(int p);
    int g = p / 2;
    int b = p % 2;
    logic [63:0] r;
    for (int s = 0; s < 2; s++) begin
      int h = 2 * (2 * b + s);
      r[32*s +: 32] = {v_res(g, h), v_res(g, h + 1)};
    end
    return r;
  endfunction

  function automatic bit hmix(int cyc, int s, int k);
    return ((cyc * 73 + s * 29 + k * 17 + cyc / 3) % 7) < 5;
  endfunction

  task automatic check(bit ok, string tag, logic [127:0] act, logic [127:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    in_valid = '0; grp_ready = 1'b0; res_valid = 1'b0; out_ready = '0;
    repeat (2) @(negedge clk);
    #1;
    check(in_ready == 2'b11, "R2 in_ready", 128'(in_ready), 128'(2'b11));
    check(grp_valid == 1'b0, "R2 grp_valid", 128'(grp_valid), 128'(0));
    check(res_ready == 1'b1, "R2 res_ready", 128'(res_ready), 128'(1));
    check(out_valid == 2'b00, "R2 out_valid", 128'(out_valid), 128'(0));
    check(out_last == 1'b0, "R2 out_last", 128'(out_last), 128'(0));
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic run_mode(int mode, int ncyc);
    int ws0 = 0, ws1 = 0, gcnt = 0, rg = 0, pc = 0;
    int stall_in = 0, stall_res = 0;
    bit g_hold = 0, p_hold = 0;
    logic [127:0] g_prev = '0;
    logic [63:0]  p_prev = '0;
    for (int cyc = 0; cyc < ncyc; cyc++) begin
      if (cyc > 0) @(negedge clk);
      case (mode)
        0: begin in_valid = 2'b11; grp_ready = 1; res_valid = 1; out_ready = 2'b11; end
        1: begin
          in_valid  = {cyc % 5 != 3, 1'b1};
          grp_ready = (cyc % 7 != 0);
          res_valid = (cyc % 4 != 1);
          out_ready = {cyc % 5 != 0, cyc % 6 != 2};
        end
        2: begin
          in_valid  = {hmix(cyc, 1, 0), hmix(cyc, 0, 0)};
          grp_ready = hmix(cyc, 0, 1);
          res_valid = hmix(cyc, 0, 2);
          out_ready = {hmix(cyc, 1, 3), hmix(cyc, 0, 3)};
        end
        default: begin
          in_valid = {cyc >= 10, 1'b1}; grp_ready = 1; res_valid = 1; out_ready = 2'b11;
        end
      endcase
      in_data  = {in_word(ws1, 1), in_word(ws0, 0)};
      res_data = res_group(rg);
      res_last = (rg % 3 == 2);
      #1;
      if (cyc < 4)
        check(half_en == cyc[0], "R1 half_en phase", 128'(half_en), 128'(cyc[0]));
      if (mode == 3 && cyc == 9) begin
        check(grp_valid == 1'b0, "R4 group held by stalled stream", 128'(grp_valid), 128'(0));
        check(in_ready[0] == 1'b0, "R4 full stream not ready", 128'(in_ready[0]), 128'(0));
      end
      if (g_hold)
        check(grp_valid && grp_data == g_prev, "R5 group stable", grp_data, g_prev);
      if (p_hold)
        check(out_valid[0] && out_data == p_prev, "R8 pair stable", 128'(out_data), 128'(p_prev));
      if (out_valid[0] != out_valid[1])
        check(1'b0, "R8 out_valid equal", 128'(out_valid), {126'b0, {2{out_valid[0]}}});
      if (mode == 0 && cyc > 2) begin
        if (in_ready != 2'b11) stall_in++;
        if (half_en && !res_ready) stall_res++;
      end
      g_hold = grp_valid && !(half_en && grp_ready);
      g_prev = grp_data;
      p_hold = out_valid[0] && !(&out_ready);
      p_prev = out_data;
      if (in_valid[0] && in_ready[0]) ws0++;
      if (in_valid[1] && in_ready[1]) ws1++;
      if (half_en && grp_valid && grp_ready) begin
        check(grp_data == in_group(gcnt), "R3 unpacked group", grp_data, in_group(gcnt));
        gcnt++;
      end
      if (half_en && res_valid && res_ready) rg++;
      if (out_valid[0] && (&out_ready)) begin
        bit exp_last = ((pc / 2) % 3 == 2) && (pc % 2 == 1);
        check(out_data == out_pair(pc), "R7 packed pair", 128'(out_data), 128'(out_pair(pc)));
        check(out_last == exp_last, "R9 end-of-frame", 128'(out_last), 128'(exp_last));
        pc++;
      end
    end
    if (mode == 0) begin
      check(stall_in == 0, "R6 input never stalled", 128'(stall_in), 128'(0));
      check(gcnt >= ncyc / 2 - 3, "R6 group rate", 128'(gcnt), 128'(ncyc / 2 - 3));
      check(stall_res == 0, "R10 result never stalled", 128'(stall_res), 128'(0));
      check(pc >= ncyc - 6, "R10 pair rate", 128'(pc), 128'(ncyc - 6));
    end else begin
      check(gcnt > 10, "R4 groups under stalls", 128'(gcnt), 128'(11));
      check(pc > 10, "R8 pairs under stalls", 128'(pc), 128'(11));
    end
  endtask

  initial begin
    #400000;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
    $finish;
  end

  initial begin
    for (int m = 0; m < 4; m++) begin
      do_reset();
      run_mode(m, 400);
    end
    summary();
    $finish;
  end
endmodule